// File: doc/BRIEF.md
# Automatic Media Port Selector

This block decides which of two media attachments an Ethernet transceiver uses: the twisted-pair port or the attachment-unit (AUI) port. In automatic mode it watches two indications from the twisted-pair receiver, a link-valid level and a frame-valid level. Link presence is held through short gaps, so one missed link pulse does not move the port. The twisted-pair port is chosen while link presence holds, and the block falls back to AUI once presence has lapsed. In manual mode a select input dictates the port.

The shared select pin is modelled as a value and an output enable. In automatic mode the pin is driven with the chosen port. In manual mode and in standby it is released. The block also says whether twisted-pair link pulses may be generated. They keep running after an automatic fallback to AUI and stop after a manual AUI choice. Each port change, each exit from standby and each reset opens a settle window of `SETTLE_CYCLES` clocks. Port-ready stays low for the whole window. With the defaults the window is 20,000 cycles of a 20 MHz clock, or 1.0 ms.

The controller has three states:
- ST_SETTLE: the window is counting down.
- ST_READY: the port is usable.
- ST_STANDBY: power-down.

Its transitions are:
- SETTLE→READY when the count expires.
- SETTLE→SETTLE or READY→SETTLE when the wanted port differs from the current one. The port flips and the window restarts.
- SETTLE→STANDBY or READY→STANDBY when standby is raised.
- STANDBY→SETTLE when standby drops. The wanted port is applied on that edge.

Top module: `port_selector`

## Requirements
- R1: In automatic mode, the wanted port is twisted pair (port_tp=1) while link presence holds and AUI (port_tp=0) otherwise. A link_ok or frame_ok sample sets presence on the next edge, and port_tp follows one edge later.
- R2: Link presence lapses only after `LOSS_CYCLES` consecutive clock edges that sample both link_ok and frame_ok low. A gap of `LOSS_CYCLES`-1 edges leaves the port unchanged.
- R3: In manual mode (auto_en=0), sel_in=1 selects twisted pair and sel_in=0 selects AUI, registered on the next edge. In automatic mode sel_in has no effect on port_tp.
- R4: In automatic mode outside standby, sel_oe=1 and sel_out equals port_tp (1 means twisted pair, 0 means AUI). In manual mode sel_oe=0.
- R5: lp_en=1 in automatic mode on either port and in manual twisted-pair mode. lp_en=0 in manual AUI mode and in standby.
- R6: After the edge that changes port_tp, port_ready stays 0 for `SETTLE_CYCLES`-1 further edges and rises on the `SETTLE_CYCLES`-th edge.
- R7: A port change requested on the edge where the settle window would expire takes priority. The port flips, port_ready stays 0 and a full window restarts.
- R8: One edge after standby=1, sel_oe=0, lp_en=0 and port_ready=0, and port_tp is held. On the edge that leaves standby, the wanted port is applied and a full settle window starts.
- R9: During reset, port_tp=0 (AUI), port_ready=0 and the state is ST_SETTLE with a full window. port_ready rises on the `SETTLE_CYCLES`-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | 1 selects automatic port choice |
| sel_in | input | 1 | Manual choice: 1 twisted pair, 0 AUI |
| link_ok | input | 1 | Twisted-pair link integrity valid |
| frame_ok | input | 1 | Valid frame seen on twisted-pair receiver |
| standby | input | 1 | Power-down request |
| port_tp | output | 1 | Selected port: 1 twisted pair, 0 AUI |
| sel_out | output | 1 | Value for the shared select pin |
| sel_oe | output | 1 | Drive enable for the shared select pin |
| lp_en | output | 1 | Twisted-pair link pulse generation allowed |
| port_ready | output | 1 | Settle window over, port usable |

## Verification
Two events can land on the same edge: the settle window expires, and a new port request arrives. The bench lets a manual change run for exactly `SETTLE_CYCLES`-1 edges, then flips sel_in so that the new request is sampled on the edge where the count would reach zero. It is judged correct when port_tp flips, port_ready stays low, and port_ready rises only a full window later. Standby entry is also raised while a link is present. The bench expects standby to win and the port to be held until exit.

// File: rtl/psel_pkg.sv
package psel_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_READY   = 2'd1,
        ST_STANDBY = 2'd2
    } psel_state_t;

    localparam logic PORT_AUI = 1'b0;
    localparam logic PORT_TP  = 1'b1;
endpackage

// File: rtl/psel_link_qual.sv
module psel_link_qual #(
    parameter int LOSS_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic frame_ok,
    output logic tp_present
);
    localparam int MW = (LOSS_CYCLES > 1) ? $clog2(LOSS_CYCLES) : 1;
    localparam logic [MW-1:0] LAST_MISS = MW'(LOSS_CYCLES - 1);

    logic [MW-1:0] miss_q;
    logic          present_q;
    logic          activity;

    assign activity = link_ok | frame_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0;
            miss_q    <= '0;
        end else if (activity) begin
            present_q <= 1'b1;
            miss_q    <= '0;
        end else if (present_q) begin
            if (miss_q == LAST_MISS) begin
                present_q <= 1'b0;
                miss_q    <= '0;
            end else begin
                miss_q <= miss_q + 1'b1;
            end
        end
    end

    assign tp_present = present_q;

    // R1: any activity sample establishes presence on the next edge
    a_r1_activity_sets: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> tp_present);

    // R2: presence never drops on an edge that sampled activity
    a_r2_no_drop_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_present && activity) |=> tp_present);
endmodule

// File: rtl/psel_ctrl.sv
module psel_ctrl
    import psel_pkg::*;
#(
    parameter int SETTLE_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic auto_en,
    input  logic sel_in,
    input  logic want_tp,
    input  logic tp_present,
    output logic port_tp,
    output logic sel_out,
    output logic sel_oe,
    output logic lp_en,
    output logic port_ready
);
    localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

    psel_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          port_q, port_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        port_d  = port_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (!standby) begin
                    state_d = ST_SETTLE;
                    cnt_d   = LOAD;
                    port_d  = want_tp;
                end
            end
            ST_SETTLE, ST_READY: begin
                if (standby) begin
                    state_d = ST_STANDBY;
                end else if (want_tp != port_q) begin
                    state_d = ST_SETTLE;
                    cnt_d   = LOAD;
                    port_d  = want_tp;
                end else if (state_q == ST_SETTLE) begin
                    if (cnt_q == '0) begin
                        state_d = ST_READY;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_SETTLE;
                cnt_d   = LOAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= LOAD;
            port_q  <= PORT_AUI;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            port_q  <= port_d;
        end
    end

    always_comb begin
        port_tp    = port_q;
        sel_out    = port_q;
        sel_oe     = auto_en && (state_q != ST_STANDBY);
        lp_en      = (state_q != ST_STANDBY) && (auto_en || port_q == PORT_TP);
        port_ready = (state_q == ST_READY);
    end

    // R6: a port flip is never seen together with a ready port
    a_r6_flip_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q != $past(port_q)) |-> !port_ready);

    // R8: standby releases the pin, stops link pulses and drops ready
    a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> (!sel_oe && !lp_en && !port_ready));

    // R5: manual AUI selection leaves link pulses off
    a_r5_manual_aui_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && $past(!auto_en && !sel_in && !standby)) |-> !lp_en);

    // R1: in automatic mode a ready port follows a change in presence
    a_r1_auto_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && auto_en && !standby && (tp_present != port_q))
        |=> (state_q == ST_SETTLE && port_q == $past(tp_present)));
endmodule

// File: rtl/port_selector.sv
module port_selector #(
    parameter int SETTLE_CYCLES = 20000,
    parameter int LOSS_CYCLES   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sel_in,
    input  logic link_ok,
    input  logic frame_ok,
    input  logic standby,
    output logic port_tp,
    output logic sel_out,
    output logic sel_oe,
    output logic lp_en,
    output logic port_ready
);
    logic tp_present;
    logic want_tp;

    psel_link_qual #(.LOSS_CYCLES(LOSS_CYCLES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ok    (link_ok),
        .frame_ok   (frame_ok),
        .tp_present (tp_present)
    );

    assign want_tp = auto_en ? tp_present : sel_in;

    psel_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .auto_en    (auto_en),
        .sel_in     (sel_in),
        .want_tp    (want_tp),
        .tp_present (tp_present),
        .port_tp    (port_tp),
        .sel_out    (sel_out),
        .sel_oe     (sel_oe),
        .lp_en      (lp_en),
        .port_ready (port_ready)
    );

    // R4: the pin is driven with the port choice whenever enabled
    a_r4_pin_value: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe |-> (auto_en && sel_out == port_tp));
endmodule

// File: tb/port_selector_bench.sv
module port_selector_bench;
    localparam int N = 8;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_en = 1'b0, sel_in = 1'b0, link_ok = 1'b0, frame_ok = 1'b0, standby = 1'b0;
    logic port_tp, sel_out, sel_oe, lp_en, port_ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    port_selector #(.SETTLE_CYCLES(N), .LOSS_CYCLES(L)) u_port_selector (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sel_in(sel_in),
        .link_ok(link_ok), .frame_ok(frame_ok), .standby(standby),
        .port_tp(port_tp), .sel_out(sel_out), .sel_oe(sel_oe),
        .lp_en(lp_en), .port_ready(port_ready)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s got %0b expected %0b", tag, act, exp);
        end
    endtask

    // port flips on the next edge, ready exactly N edges after the flip edge
    task automatic settle_window(input string tag, input logic exp_port);
        step(1);
        chk({tag, " port"}, port_tp, exp_port);
        chk({tag, " ready low at flip"}, port_ready, 1'b0);
        step(N - 1);
        chk({tag, " ready low before end"}, port_ready, 1'b0);
        step(1);
        chk({tag, " ready at end"}, port_ready, 1'b1);
    endtask

    initial begin
        // R9: reset state
        step(2);
        chk("R9 reset port", port_tp, 1'b0);
        chk("R9 reset ready", port_ready, 1'b0);
        chk("R4 reset oe", sel_oe, 1'b0);
        chk("R5 reset lp manual aui", lp_en, 1'b0);
        rst_n = 1'b1;
        step(N - 1);
        chk("R9 ready low before window end", port_ready, 1'b0);
        step(1);
        chk("R9 ready after window", port_ready, 1'b1);

        // R3 manual sweep, R6 window timing, R5 pulses
        sel_in = 1'b1;
        settle_window("R3 R6 manual tp", 1'b1);
        chk("R5 lp manual tp", lp_en, 1'b1);
        chk("R4 oe manual", sel_oe, 1'b0);

        // R7: request on the expiry edge restarts the window
        sel_in = 1'b0;
        step(1);
        chk("R7 first flip", port_tp, 1'b0);
        step(N - 1);
        chk("R7 ready low before expiry", port_ready, 1'b0);
        sel_in = 1'b1;
        settle_window("R7 restart", 1'b1);

        sel_in = 1'b0;
        settle_window("R3 manual aui", 1'b0);
        chk("R5 lp manual aui", lp_en, 1'b0);

        // automatic mode, no link: AUI, pulses on, pin driven
        auto_en = 1'b1;
        step(1);
        chk("R1 auto no link port", port_tp, 1'b0);
        chk("R4 auto oe", sel_oe, 1'b1);
        chk("R4 auto pin aui", sel_out, 1'b0);
        chk("R5 lp auto aui", lp_en, 1'b1);
        chk("R1 no change keeps ready", port_ready, 1'b1);

        // R3: sel_in ignored in auto
        sel_in = 1'b1;
        step(3);
        chk("R3 sel_in ignored in auto", port_tp, 1'b0);
        chk("R3 ready undisturbed", port_ready, 1'b1);

        // R1: link appears
        link_ok = 1'b1;
        step(1);
        chk("R1 presence latency port", port_tp, 1'b0);
        settle_window("R1 link tp", 1'b1);
        chk("R4 auto pin tp", sel_out, 1'b1);
        chk("R5 lp auto tp", lp_en, 1'b1);

        // R2: short gap ignored
        link_ok = 1'b0;
        step(L - 1);
        link_ok = 1'b1;
        step(2);
        chk("R2 short gap port", port_tp, 1'b1);
        chk("R2 short gap ready", port_ready, 1'b1);

        // R2: full gap drops presence
        link_ok = 1'b0;
        step(L);
        chk("R2 port held at lapse edge", port_tp, 1'b1);
        settle_window("R2 fallback aui", 1'b0);
        chk("R5 lp after auto fallback", lp_en, 1'b1);

        // R1: frame activity alone selects twisted pair
        frame_ok = 1'b1;
        step(1);
        frame_ok = 1'b0;
        step(1);
        chk("R1 frame selects tp", port_tp, 1'b1);
        step(L + N + 2);
        chk("R1 frame decay port", port_tp, 1'b0);
        chk("R1 frame decay ready", port_ready, 1'b1);

        // R8: standby raised together with a link
        standby = 1'b1;
        link_ok = 1'b1;
        step(1);
        chk("R8 oe released", sel_oe, 1'b0);
        chk("R8 lp off", lp_en, 1'b0);
        chk("R8 ready low", port_ready, 1'b0);
        step(5);
        chk("R8 port held", port_tp, 1'b0);
        standby = 1'b0;
        settle_window("R8 exit applies port", 1'b1);
        chk("R8 oe back", sel_oe, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule